// File: doc/BRIEF.md
# Gated Bit Error Monitor

This block sits behind a receiver that has already been aligned to a known test pattern. On each clock with a valid flag it takes one received bit and the bit that should have arrived. It compares the two and keeps four saturating counters: bits compared, bits in error, errors where a one was expected, and errors where a zero was expected. A software-visible clear zeroes the counters without disturbing anything else.

For a coarse real-time view, the valid bit stream is cut into fixed segments of `SEG_LEN` bits, counted from reset. When any counted error falls inside a segment, a flag output goes high for `SEG_LEN` clock periods once that segment closes. A gate input lets the surrounding logic mask stretches of traffic, such as bursts that carry no pattern. Masking is applied in whole chunks of `CHUNK_LEN` valid bits. The chunk starts with the first bit seen while the gate is high. It is extended chunk by chunk until the gate is low on a chunk's final bit. The segment grid keeps running through gated stretches.

Top module: `bit_error_monitor`

## Requirements
- R1: The compared-bit count rises by exactly one for each cycle with `bit_valid` high that is not gated. A cycle with `bit_valid` low changes no counter, no segment position and no gate span.
- R2: The error count rises by one for each counted bit where `rx_bit` differs from `ref_bit`.
- R3: A counted error with `ref_bit`=1 increments the expected-one count, and a counted error with `ref_bit`=0 increments the expected-zero count. While the error count is below its maximum, it equals the sum of these two counts.
- R4: Every counter stops at 2^CNT_W-1 and never wraps.
- R5: `clear` high on a clock edge leaves all four counters at zero after that edge. This takes priority over any increment in the same cycle.
- R6: A valid bit presented while `gate` is high is ignored, as is every following bit until the gated span closes. Ignored bits touch no counter and contribute nothing to the segment error flag.
- R7: A gated span always covers a whole multiple of CHUNK_LEN valid bits, counted from its first ignored bit. It closes after a chunk's last bit that arrives with `gate` low, and counting resumes with the next valid bit.
- R8: `gated` is low until the first ignored bit of a span has been clocked. It stays high up to and including the edge that clocks the span's last bit, and is low after that edge.
- R9: Segments of SEG_LEN valid bits are counted from reset and keep advancing while gated. Cycles without `bit_valid` do not advance them.
- R10: If a segment holds at least one counted error, `err_flag` is high for exactly SEG_LEN clock cycles, starting the cycle after the edge that clocks the segment's last bit. A flagged segment that closes while the flag is high restarts the full length.
- R11: After reset, all counters, `err_flag` and `gated` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received bit |
| ref_bit | input | 1 | Expected bit |
| bit_valid | input | 1 | Marks a cycle that carries a bit |
| gate | input | 1 | Request to ignore incoming bits |
| clear | input | 1 | Synchronous clear of all counters |
| compared_cnt | output | CNT_W | Bits compared |
| error_cnt | output | CNT_W | Bits in error |
| err_on_one_cnt | output | CNT_W | Errors on expected ones |
| err_on_zero_cnt | output | CNT_W | Errors on expected zeros |
| err_flag | output | 1 | Stretched per-segment error indication |
| gated | output | 1 | High while a gated span is in force |

## Verification
The bench pulses the gate for a single bit and then checks the compared count. A design that masked bit by bit, or one that measured the span from the segment grid, would be off by hundreds. It also keeps one chunk-closing bit with the gate low and another with the gate high; a design that released the gate at the wrong chunk end would miscount both. A run of all-error bits drives every counter past its top, where a wrapping counter would read near zero. A lone error is then timed against the segment grid: a pulse one cycle short or long, or one that starts on the error instead of at the segment's close, shows up in the flag's high-cycle count. A clear that arrives together with an error bit exposes a design that lets the increment win.

// File: rtl/bem_pkg.sv
package bem_pkg;
    // Per-bit classification produced by the top and consumed by the counters.
    typedef struct packed {
        logic counted;   // valid and outside a gated span
        logic is_err;    // counted and mismatching
        logic err_one;   // counted error on an expected one
        logic err_zero;  // counted error on an expected zero
    } bit_verdict_t;

    localparam int unsigned NUM_COUNTERS = 4;
endpackage

// File: rtl/bem_gate_ctrl.sv
// Gate span controller.
// Turns the level gate request into a mask that lasts a whole number of
// CHUNK_LEN valid bits. It assumes CHUNK_LEN >= 2. Only cycles that carry a
// valid bit advance the span position.
module bem_gate_ctrl #(
    parameter int unsigned CHUNK_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic gate,
    output logic ignore_bit,
    output logic gated
);
    localparam int unsigned SPAN_W = $clog2(CHUNK_LEN);
    localparam logic [SPAN_W-1:0] SPAN_LAST = SPAN_W'(CHUNK_LEN - 1);

    logic              gated_q;
    logic [SPAN_W-1:0] span_q;
    logic              chunk_done;

    // The current bit is masked if a span is open or the gate is asserted now.
    assign ignore_bit = gate | gated_q;
    assign chunk_done = gated_q && (span_q == SPAN_LAST);
    assign gated      = gated_q;

    // Track the open span and its position, releasing it only at a chunk end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_q <= 1'b0;
            span_q  <= '0;
        end else if (bit_valid) begin
            if (!gated_q) begin
                if (gate) begin
                    gated_q <= 1'b1;
                    span_q  <= SPAN_W'(1);
                end
            end else if (chunk_done) begin
                span_q <= '0;
                if (!gate) gated_q <= 1'b0;
            end else begin
                span_q <= span_q + 1'b1;
            end
        end
    end

    assert_release_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gated_q) |-> ($past(span_q) == SPAN_LAST) && !$past(gate) && $past(bit_valid));

    assert_gate_opens_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && gate && !gated_q) |=> gated_q);

    assert_idle_holds_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(span_q) && $stable(gated_q));
endmodule

// File: rtl/bem_sat_counter.sv
// Saturating event counter with synchronous clear.
// It counts one per cycle with inc high and holds at all-ones. Clear wins
// over an increment in the same cycle.
module bem_sat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up to the ceiling, clearing on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (clr)                      count <= '0;
        else if (inc && (count != CNT_MAX)) count <= count + 1'b1;
    end

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == CNT_MAX && !$past(clr)) |-> count == CNT_MAX);

    assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/bem_seg_flag.sv
// Segment error flag generator.
// It splits the valid bit stream into SEG_LEN-bit segments, counted from
// reset and independent of gating. A segment that saw a counted error
// raises the flag for PULSE_LEN clock cycles. It assumes SEG_LEN >= 2 and
// that bit_err is only high together with bit_valid.
module bem_seg_flag #(
    parameter int unsigned SEG_LEN   = 128,
    parameter int unsigned PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_err,
    output logic err_flag
);
    localparam int unsigned SEG_W   = $clog2(SEG_LEN);
    localparam int unsigned PULSE_W = $clog2(PULSE_LEN + 1);
    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_LEN - 1);

    logic [SEG_W-1:0]   seg_q;
    logic               seg_err_q;
    logic [PULSE_W-1:0] pulse_q;
    logic               seg_end;
    logic               seg_hit;

    assign seg_end  = bit_valid && (seg_q == SEG_LAST);
    assign seg_hit  = seg_err_q | bit_err;
    assign err_flag = (pulse_q != '0);

    // Advance the segment position and collect its error OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q     <= '0;
            seg_err_q <= 1'b0;
        end else if (seg_end) begin
            seg_q     <= '0;
            seg_err_q <= 1'b0;
        end else if (bit_valid) begin
            seg_q     <= seg_q + 1'b1;
            seg_err_q <= seg_hit;
        end
    end

    // Load the stretch counter on a flagged segment end, otherwise run it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pulse_q <= '0;
        else if (seg_end && seg_hit) pulse_q <= PULSE_W'(PULSE_LEN);
        else if (pulse_q != '0)     pulse_q <= pulse_q - 1'b1;
    end

    assert_flag_starts_at_segment_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(seg_end && seg_hit));

    assert_flag_follows_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && seg_hit) |=> err_flag && (pulse_q == PULSE_W'(PULSE_LEN)));

    assert_flag_ends_on_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(pulse_q) == PULSE_W'(1));

    assert_segment_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(seg_q));
endmodule

// File: rtl/bit_error_monitor.sv
// Gated bit error monitor (top).
// It compares one received bit against its expected value per valid cycle,
// keeps four saturating counters, masks gated spans in whole chunks and
// raises a stretched flag for each segment with errors. It assumes the
// stream is already aligned to the reference pattern.
module bit_error_monitor #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned SEG_LEN   = 128,
    parameter int unsigned CHUNK_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             ref_bit,
    input  logic             bit_valid,
    input  logic             gate,
    input  logic             clear,
    output logic [CNT_W-1:0] compared_cnt,
    output logic [CNT_W-1:0] error_cnt,
    output logic [CNT_W-1:0] err_on_one_cnt,
    output logic [CNT_W-1:0] err_on_zero_cnt,
    output logic             err_flag,
    output logic             gated
);
    import bem_pkg::*;

    localparam int unsigned     PULSE_LEN = SEG_LEN;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic                       ignore_bit;
    bit_verdict_t               verdict;
    logic [NUM_COUNTERS-1:0]    inc_vec;
    logic [CNT_W-1:0]           cnt_arr [NUM_COUNTERS];

    bem_gate_ctrl #(.CHUNK_LEN(CHUNK_LEN)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .gate       (gate),
        .ignore_bit (ignore_bit),
        .gated      (gated)
    );

    // Classify the current bit for the counters and the segment flag.
    always_comb begin
        verdict.counted  = bit_valid & ~ignore_bit;
        verdict.is_err   = verdict.counted & (rx_bit ^ ref_bit);
        verdict.err_one  = verdict.is_err & ref_bit;
        verdict.err_zero = verdict.is_err & ~ref_bit;
    end

    assign inc_vec = {verdict.err_zero, verdict.err_one, verdict.is_err, verdict.counted};

    for (genvar k = 0; k < NUM_COUNTERS; k++) begin : g_cnt
        bem_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .inc   (inc_vec[k]),
            .count (cnt_arr[k])
        );
    end

    assign compared_cnt    = cnt_arr[0];
    assign error_cnt       = cnt_arr[1];
    assign err_on_one_cnt  = cnt_arr[2];
    assign err_on_zero_cnt = cnt_arr[3];

    bem_seg_flag #(.SEG_LEN(SEG_LEN), .PULSE_LEN(PULSE_LEN)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_err   (verdict.is_err),
        .err_flag  (err_flag)
    );

    assert_split_sums_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (error_cnt != CNT_MAX) |->
            ({1'b0, error_cnt} == ({1'b0, err_on_one_cnt} + {1'b0, err_on_zero_cnt})));

    assert_gated_bits_uncounted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && bit_valid && !clear) |=> $stable(compared_cnt) && $stable(error_cnt));

    assert_errors_within_compared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error_cnt <= compared_cnt);
endmodule

// File: tb/bit_error_monitor_tb_top.sv
module bit_error_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int SEG_LEN    = 128;
    localparam int CHUNK_LEN  = 512;
    localparam int MAXC       = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n, rx_bit, ref_bit, bit_valid, gate, clear;
    logic [CNT_W-1:0] compared_cnt, error_cnt, err_on_one_cnt, err_on_zero_cnt;
    logic err_flag, gated;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state derived from the requirements.
    int m_bits, m_err, m_one, m_zero, m_span, m_seg, m_pulse;
    bit m_gated, m_segerr;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_error_monitor #(.CNT_W(CNT_W), .SEG_LEN(SEG_LEN), .CHUNK_LEN(CHUNK_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .ref_bit(ref_bit),
        .bit_valid(bit_valid), .gate(gate), .clear(clear),
        .compared_cnt(compared_cnt), .error_cnt(error_cnt),
        .err_on_one_cnt(err_on_one_cnt), .err_on_zero_cnt(err_on_zero_cnt),
        .err_flag(err_flag), .gated(gated)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_bits = 0; m_err = 0; m_one = 0; m_zero = 0;
        m_span = 0; m_seg = 0; m_pulse = 0; m_gated = 0; m_segerr = 0;
    endfunction

    function automatic void model_step(bit v, bit r, bit e, bit g, bit c);
        bit ign, cnt_ok, errc, loaded, hit, n_gated;
        int n_span;
        ign = g || m_gated;
        cnt_ok = v && !ign;
        errc = cnt_ok && (r != e);
        n_gated = m_gated; n_span = m_span;
        if (v) begin
            if (!m_gated) begin
                if (g) begin n_gated = 1; n_span = 1; end
            end else if (m_span == CHUNK_LEN - 1) begin
                n_span = 0;
                if (!g) n_gated = 0;
            end else n_span = m_span + 1;
        end
        if (c) begin
            m_bits = 0; m_err = 0; m_one = 0; m_zero = 0;
        end else begin
            if (cnt_ok && m_bits < MAXC) m_bits++;
            if (errc && m_err < MAXC) m_err++;
            if (errc && e && m_one < MAXC) m_one++;
            if (errc && !e && m_zero < MAXC) m_zero++;
        end
        loaded = 0;
        if (v) begin
            hit = m_segerr || errc;
            if (m_seg == SEG_LEN - 1) begin
                m_seg = 0; m_segerr = 0;
                if (hit) begin m_pulse = SEG_LEN; loaded = 1; end
            end else begin
                m_seg++; m_segerr = hit;
            end
        end
        if (!loaded && m_pulse != 0) m_pulse--;
        m_gated = n_gated; m_span = n_span;
    endfunction

    task automatic compare_all();
        chk("R1 compared_cnt", int'(compared_cnt), m_bits);
        chk("R2 error_cnt", int'(error_cnt), m_err);
        chk("R3 err_on_one_cnt", int'(err_on_one_cnt), m_one);
        chk("R3 err_on_zero_cnt", int'(err_on_zero_cnt), m_zero);
        chk("R10 err_flag", int'(err_flag), int'(m_pulse != 0));
        chk("R8 gated", int'(gated), int'(m_gated));
    endtask

    // Apply one cycle of stimulus, advance the model, sample after the edge.
    task automatic drive(input bit v, input bit r, input bit e, input bit g, input bit c);
        bit_valid = v; rx_bit = r; ref_bit = e; gate = g; clear = c;
        model_step(v, r, e, g, c);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_phase(input int n, input int pv, input int perr, input int ptog, input int pclr);
        bit g = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit v, e, r, c;
            if (ptog != 0 && $urandom_range(999) < ptog) g = ~g;
            v = ($urandom_range(99) < pv);
            e = $urandom_range(1);
            r = ($urandom_range(99) < perr) ? ~e : e;
            c = ($urandom_range(9999) < pclr);
            drive(v, r, e, g, c);
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 2000; i++) begin
            if (!m_gated && m_pulse == 0 && m_seg == 0) break;
            drive(1, 0, 0, 0, 0);
        end
    endtask

    initial begin
        int hi;
        void'($urandom(32'h5EED_0B17));
        rst_n = 0; bit_valid = 0; rx_bit = 0; ref_bit = 0; gate = 0; clear = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 compared_cnt", int'(compared_cnt), 0);
        chk("R11 error_cnt", int'(error_cnt), 0);
        chk("R11 err_on_one_cnt", int'(err_on_one_cnt), 0);
        chk("R11 err_on_zero_cnt", int'(err_on_zero_cnt), 0);
        chk("R11 err_flag", int'(err_flag), 0);
        chk("R11 gated", int'(gated), 0);
        rst_n = 1;

        // R1/R2/R3/R9/R10 ungated random traffic, sparse then dense errors
        rand_phase(3000, 70, 1, 0, 0);
        rand_phase(2000, 90, 20, 0, 0);
        // R6/R7/R8 random gate toggling mixed with clears (R5)
        rand_phase(20000, 80, 5, 4, 5);
        rand_phase(8000, 50, 2, 20, 0);

        // R7: one-bit gate pulse masks a whole chunk
        settle();
        drive(0, 0, 0, 0, 1);
        drive(1, 1, 0, 1, 0);
        for (int i = 0; i < 600; i++) drive(1, 0, 0, 0, 0);
        chk("R7 one-chunk span count", int'(compared_cnt), 601 - CHUNK_LEN);
        chk("R7 single error ignored", int'(error_cnt), 0);

        // R7: gate high on a chunk's last bit extends to a second chunk
        settle();
        drive(0, 0, 0, 0, 1);
        drive(1, 0, 0, 1, 0);
        for (int i = 1; i < CHUNK_LEN - 1; i++) drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 1, 0);
        chk("R8 gated at chunk end", int'(gated), 1);
        for (int i = 0; i < CHUNK_LEN + 10; i++) drive(1, 1, 1, 0, 0);
        chk("R7 two-chunk span count", int'(compared_cnt), 10);

        // R4: saturation of all counters with expected zeros in error
        settle();
        drive(0, 0, 0, 0, 1);
        for (int i = 0; i < MAXC + 80; i++) drive(1, 1, 0, 0, 0);
        chk("R4 compared saturates", int'(compared_cnt), MAXC);
        chk("R4 error saturates", int'(error_cnt), MAXC);
        chk("R4 zero-errors saturate", int'(err_on_zero_cnt), MAXC);
        chk("R3 one-errors untouched", int'(err_on_one_cnt), 0);

        // R5: clear wins over a simultaneous error bit
        drive(1, 0, 1, 0, 1);
        chk("R5 clear priority compared", int'(compared_cnt), 0);
        chk("R5 clear priority errors", int'(error_cnt), 0);

        // R1: invalid cycles change nothing
        drive(1, 0, 1, 0, 0);
        for (int i = 0; i < 50; i++) drive(0, 1, 0, 0, 0);
        chk("R1 idle hold compared", int'(compared_cnt), 1);
        chk("R1 idle hold one-errors", int'(err_on_one_cnt), 1);

        // R10/R9: one error in a segment gives a flag of exactly SEG_LEN cycles
        settle();
        drive(1, 1, 0, 0, 0);
        for (int i = 1; i < SEG_LEN; i++) drive(1, 0, 0, 0, 0);
        hi = err_flag ? 1 : 0;
        for (int i = 0; i < SEG_LEN + 72; i++) begin
            drive(0, 0, 0, 0, 0);
            if (err_flag) hi++;
        end
        chk("R10 flag length", hi, SEG_LEN);

        // R10: flag restarts for back-to-back flagged segments
        for (int i = 0; i < 3 * SEG_LEN; i++) drive(1, (i % SEG_LEN) == 5, 0, 0, 0);
        chk("R10 flag held across segments", int'(err_flag), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule